// File: doc/BRIEF.md
# DDS Parameter Source Selector

This block decides, once per parameter clock, where each of the three control values of a direct digital synthesis core comes from. The three values are a 32-bit frequency tuning word, a 16-bit phase offset and a 12-bit amplitude scale. The candidate sources are eight stored profiles, a ramp generator word, a parallel data word and an amplitude-keying value. The profiles are selected by a 3-bit input, and each profile holds one value for each of the three parameters.

Several sources may be enabled at the same time. For each parameter, a fixed priority picks one winner. The parallel word ranks first, then the ramp word, then the selected profile. For the amplitude alone, the keying value ranks above all of these. All inputs are sampled on the same rising edge, and the three results are registered together, so the core never sees a mixed set of values.

Top module: `dds_param_select`

## Requirements
- R1: While `rst_n` is low, all three outputs read zero.
- R2: When no modulation source drives a parameter, that output equals the value of the profile chosen by `prof_sel`, as sampled on the preceding rising edge.
- R3: When `osk_en` is high, `asf_q` equals `osk_val`, whatever the other sources and `amp_en` hold.
- R4: When keying is off and the parallel word does not drive amplitude, a low `amp_en` forces `asf_q` to full scale (all ones). In that case profile and ramp amplitudes have no effect.
- R5: `ramp_dest` routes the ramp word as follows. Code 0 sends it to frequency using all 32 bits. Code 1 sends it to phase using bits [31:16]. Code 2 sends it to amplitude using bits [31:20]. Code 3 drives nothing. The ramp acts only while `ramp_en` is high.
- R6: `par_dest` routes the parallel word, taken as unsigned, as follows. Code 0 drives frequency from bits [31:0]. Code 1 drives phase from bits [31:16]. Code 2 drives amplitude from bits [31:20]. Code 3 is polar: phase from bits [31:16] and amplitude from bits [15:4]. The parallel word acts only while `par_en` is high.
- R7: On the same parameter, the parallel word wins over the ramp, and the ramp wins over the profile.
- R8: A change on any input appears at the outputs only at the next rising edge, and all three outputs update on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parameter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_sel | input | 3 | Active profile select |
| prof_ftw | input | 256 | Eight profile frequency words, profile k at bits [32k+31:32k] |
| prof_pow | input | 128 | Eight profile phase words, profile k at bits [16k+15:16k] |
| prof_asf | input | 96 | Eight profile amplitude words, profile k at bits [12k+11:12k] |
| amp_en | input | 1 | Amplitude scaling enable |
| osk_en | input | 1 | Amplitude keying enable |
| osk_val | input | 12 | Amplitude keying value |
| ramp_en | input | 1 | Ramp source enable |
| ramp_dest | input | 2 | Ramp destination code |
| ramp_val | input | 32 | Ramp generator word |
| par_en | input | 1 | Parallel source enable |
| par_dest | input | 2 | Parallel destination code |
| par_word | input | 32 | Parallel data word |
| ftw_q | output | 32 | Registered frequency tuning word |
| pow_q | output | 16 | Registered phase offset |
| asf_q | output | 12 | Registered amplitude scale |

## Verification
The hardest case to reach is a full collision. This happens when keying, the parallel word in polar mode and the ramp aimed at amplitude are all active at once, with `amp_en` low, and each layer must then be removed one at a time. Directed steps build that stack and peel it apart. Random steps then draw the enables and destination codes independently, so that overlapping sources occur often. Each step also checks the outputs shortly after the inputs change and before the next edge, to catch any unregistered path.

// File: rtl/dds_param_select.sv
module dds_param_select #(
  parameter int NPROF = 8,
  parameter int FW = 32,
  parameter int PW = 16,
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int SELW = $clog2(NPROF)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SELW-1:0]     prof_sel,
  input  logic [NPROF*FW-1:0] prof_ftw,
  input  logic [NPROF*PW-1:0] prof_pow,
  input  logic [NPROF*AW-1:0] prof_asf,
  input  logic                amp_en,
  input  logic                osk_en,
  input  logic [AW-1:0]       osk_val,
  input  logic                ramp_en,
  input  logic [1:0]          ramp_dest,
  input  logic [DW-1:0]       ramp_val,
  input  logic                par_en,
  input  logic [1:0]          par_dest,
  input  logic [DW-1:0]       par_word,
  output logic [FW-1:0]       ftw_q,
  output logic [PW-1:0]       pow_q,
  output logic [AW-1:0]       asf_q
);
  localparam logic [1:0] DEST_FREQ = 2'd0;
  localparam logic [1:0] DEST_PHASE = 2'd1;
  localparam logic [1:0] DEST_AMP = 2'd2;
  localparam logic [1:0] DEST_POLAR = 2'd3;

  logic [FW-1:0] sel_ftw;
  logic [PW-1:0] sel_pow;
  logic [AW-1:0] sel_asf;
  assign sel_ftw = prof_ftw[prof_sel*FW +: FW];
  assign sel_pow = prof_pow[prof_sel*PW +: PW];
  assign sel_asf = prof_asf[prof_sel*AW +: AW];

  logic ramp_f, ramp_p, ramp_a;
  assign ramp_f = ramp_en && (ramp_dest == DEST_FREQ);
  assign ramp_p = ramp_en && (ramp_dest == DEST_PHASE);
  assign ramp_a = ramp_en && (ramp_dest == DEST_AMP);

  logic par_f, par_p, par_a;
  assign par_f = par_en && (par_dest == DEST_FREQ);
  assign par_p = par_en && (par_dest == DEST_PHASE || par_dest == DEST_POLAR);
  assign par_a = par_en && (par_dest == DEST_AMP || par_dest == DEST_POLAR);

  logic [AW-1:0] par_amp;
  assign par_amp = (par_dest == DEST_POLAR) ? par_word[DW-PW-1 -: AW] : par_word[DW-1 -: AW];

  logic [FW-1:0] ftw_d;
  logic [PW-1:0] pow_d;
  logic [AW-1:0] asf_d;
  assign ftw_d = par_f  ? par_word[DW-1 -: FW] :
                 ramp_f ? ramp_val[DW-1 -: FW] : sel_ftw;
  assign pow_d = par_p  ? par_word[DW-1 -: PW] :
                 ramp_p ? ramp_val[DW-1 -: PW] : sel_pow;
  assign asf_d = osk_en  ? osk_val :
                 par_a   ? par_amp :
                 !amp_en ? {AW{1'b1}} :
                 ramp_a  ? ramp_val[DW-1 -: AW] : sel_asf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q <= '0;
      pow_q <= '0;
      asf_q <= '0;
    end else begin
      ftw_q <= ftw_d;
      pow_q <= pow_d;
      asf_q <= asf_d;
    end
  end
endmodule

module dds_param_select_chk #(
  parameter int NPROF = 8,
  parameter int FW = 32,
  parameter int PW = 16,
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int SELW = $clog2(NPROF)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SELW-1:0]     prof_sel,
  input logic [NPROF*FW-1:0] prof_ftw,
  input logic [NPROF*PW-1:0] prof_pow,
  input logic                amp_en,
  input logic                osk_en,
  input logic [AW-1:0]       osk_val,
  input logic                ramp_en,
  input logic [1:0]          ramp_dest,
  input logic [DW-1:0]       ramp_val,
  input logic                par_en,
  input logic [1:0]          par_dest,
  input logic [DW-1:0]       par_word,
  input logic [FW-1:0]       ftw_q,
  input logic [PW-1:0]       pow_q,
  input logic [AW-1:0]       asf_q
);
  always_comb if (!rst_n) p_reset_zero_r1: assert (ftw_q == '0 && pow_q == '0 && asf_q == '0);

  p_profile_freq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en && !ramp_en) |=> ftw_q == $past(prof_ftw[prof_sel*FW +: FW]));

  p_profile_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en && !ramp_en) |=> pow_q == $past(prof_pow[prof_sel*PW +: PW]));

  p_keying_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osk_en |=> asf_q == $past(osk_val));

  p_amp_off_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!osk_en && !amp_en && !par_en) |=> asf_q == {AW{1'b1}});

  p_ramp_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && ramp_dest == 2'd1 && !par_en) |=> pow_q == $past(ramp_val[DW-1 -: PW]));

  p_par_freq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en && par_dest == 2'd0) |=> ftw_q == $past(par_word[DW-1 -: FW]));

  p_polar_amp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!osk_en && par_en && par_dest == 2'd3) |=> asf_q == $past(par_word[DW-PW-1 -: AW]));
endmodule

bind dds_param_select dds_param_select_chk #(
  .NPROF(NPROF), .FW(FW), .PW(PW), .AW(AW), .DW(DW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .prof_ftw(prof_ftw), .prof_pow(prof_pow),
  .amp_en(amp_en), .osk_en(osk_en), .osk_val(osk_val), .ramp_en(ramp_en),
  .ramp_dest(ramp_dest), .ramp_val(ramp_val), .par_en(par_en), .par_dest(par_dest),
  .par_word(par_word), .ftw_q(ftw_q), .pow_q(pow_q), .asf_q(asf_q)
);

// File: tb/dds_param_select_tb.sv
module dds_param_select_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] prof_sel = '0;
  logic [255:0] prof_ftw = '0;
  logic [127:0] prof_pow = '0;
  logic [95:0] prof_asf = '0;
  logic amp_en = 1'b0, osk_en = 1'b0, ramp_en = 1'b0, par_en = 1'b0;
  logic [11:0] osk_val = '0;
  logic [1:0] ramp_dest = '0, par_dest = '0;
  logic [31:0] ramp_val = '0, par_word = '0;
  logic [31:0] ftw_q;
  logic [15:0] pow_q;
  logic [11:0] asf_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [59:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  dds_param_select dut_i (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .prof_ftw(prof_ftw),
    .prof_pow(prof_pow), .prof_asf(prof_asf), .amp_en(amp_en), .osk_en(osk_en),
    .osk_val(osk_val), .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_val(ramp_val),
    .par_en(par_en), .par_dest(par_dest), .par_word(par_word),
    .ftw_q(ftw_q), .pow_q(pow_q), .asf_q(asf_q)
  );

  function automatic logic [59:0] model();
    logic [31:0] f;
    logic [15:0] p;
    logic [11:0] a;
    f = prof_ftw[prof_sel*32 +: 32];
    p = prof_pow[prof_sel*16 +: 16];
    a = prof_asf[prof_sel*12 +: 12];
    if (ramp_en && ramp_dest == 2'd0) f = ramp_val;
    if (ramp_en && ramp_dest == 2'd1) p = ramp_val[31:16];
    if (ramp_en && ramp_dest == 2'd2) a = ramp_val[31:20];
    if (!amp_en) a = 12'hfff;
    if (par_en) begin
      case (par_dest)
        2'd0: f = par_word;
        2'd1: p = par_word[31:16];
        2'd2: a = par_word[31:20];
        default: begin p = par_word[31:16]; a = par_word[15:4]; end
      endcase
    end
    if (osk_en) a = osk_val;
    return {f, p, a};
  endfunction

  task automatic check(string req, logic [59:0] got, logic [59:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(string req);
    logic [59:0] e;
    e = model();
    #1 check("R8 hold before edge", {ftw_q, pow_q, asf_q}, prev_exp);
    @(negedge clk);
    check(req, {ftw_q, pow_q, asf_q}, e);
    prev_exp = e;
  endtask

  task automatic clear_mods();
    osk_en = 0; ramp_en = 0; par_en = 0; amp_en = 1;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5a7));
    for (int k = 0; k < 8; k++) begin
      prof_ftw[k*32 +: 32] = $urandom;
      prof_pow[k*16 +: 16] = 16'($urandom);
      prof_asf[k*12 +: 12] = 12'($urandom);
    end
    amp_en = 1;
    prof_sel = 3'd5;
    repeat (3) @(negedge clk);
    check("R1 reset zero", {ftw_q, pow_q, asf_q}, 60'd0);
    rst_n = 1;
    prev_exp = '0;

    for (int k = 0; k < 8; k++) begin
      prof_sel = 3'(k);
      step("R2 profile select");
    end
    osk_en = 1; osk_val = 12'h5a5; par_en = 1; par_dest = 2'd3; par_word = 32'hdeadbeef;
    ramp_en = 1; ramp_dest = 2'd2; ramp_val = 32'h89abcdef; amp_en = 0;
    step("R3 keying over full stack");
    osk_en = 0;
    step("R6 polar amplitude after keying off");
    par_dest = 2'd0;
    step("R4 amp disabled forces full scale");
    amp_en = 1;
    step("R5 ramp to amplitude");
    ramp_en = 0;
    step("R2 profile amplitude restored");
    clear_mods(); amp_en = 0;
    step("R4 profile amplitude masked");
    amp_en = 1; ramp_en = 1; ramp_val = 32'hfedc1234;
    for (int d = 0; d < 4; d++) begin
      ramp_dest = 2'(d);
      step("R5 ramp destination");
    end
    clear_mods(); par_en = 1; par_word = 32'h13579bdf;
    for (int d = 0; d < 4; d++) begin
      par_dest = 2'(d);
      step("R6 parallel destination");
    end
    ramp_en = 1; ramp_dest = 2'd0; par_dest = 2'd0;
    step("R7 parallel over ramp on frequency");
    par_dest = 2'd1;
    step("R7 ramp over profile on frequency");
    prof_sel = 3'd2; par_word = 32'h0; ramp_val = 32'h1;
    step("R8 all outputs change together");

    for (int n = 0; n < 600; n++) begin
      prof_sel = 3'($urandom);
      amp_en = 1'($urandom);
      osk_en = ($urandom % 4) == 0;
      osk_val = 12'($urandom);
      ramp_en = 1'($urandom);
      ramp_dest = 2'($urandom);
      ramp_val = $urandom;
      par_en = 1'($urandom);
      par_dest = 2'($urandom);
      par_word = $urandom;
      step("R7 random priority mix");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule